// File: doc/BRIEF.md
# Float-Scale Requantization Unit

This block turns 32-bit multiply-accumulate results into signed 8-bit values. It is the last step of an integer matrix multiply, where activations, weights and outputs are all 8-bit with a per-tensor scale and zero point. A single combined scale covers one matrix multiply. That scale is the input scale times the weight scale, divided by the output scale. It arrives as the bit pattern of an IEEE-754 single-precision float, together with a signed 8-bit output zero point.

On a configuration load the unit decodes the float bits straight into two values, using a fixed bias formula:

- a 16-bit multiplier, equal to the top fifteen mantissa bits plus one;
- a signed shift, equal to 142 minus the biased exponent field.

Both values are registered and hold until the next load.

Each accumulator sample is then multiplied by the multiplier into a 48-bit product. The product is shifted right with round-half-up rounding. The zero point is added and the result is clamped to the 8-bit range. The stream moves one sample per cycle over valid/ready handshakes, with a fixed latency of two cycles. Configuration is loaded only while the pipeline is empty.

Top module: `requant_unit`

## Requirements
- R1: The shift amount is 142 minus the exponent field, bits 30 to 23 of the scale pattern. The output equals round_half_up(acc * multiplier / 2^shift) + zero point, then clamped.
- R2: The multiplier is bits 22 to 8 of the scale pattern, read as an unsigned number, plus one. Its range is 1 to 32768.
- R3: For a shift from 1 to 47, the 48-bit product has 2^(shift-1) added to it and is then arithmetically shifted right. Exact halves round toward plus infinity: 1.5 gives 2 and -1.5 gives -1.
- R4: The sum of the scaled value and the zero point saturates to the range -128 to 127.
- R5: A shift of 48 or more gives the zero point alone.
- R6: A shift of zero or less shifts the product left by the negated amount. A nonzero product shifted left by 16 or more saturates toward its own sign. A zero product stays zero.
- R7: When bit 31 (the sign) of a loaded scale pattern is set, the configuration error output is high from the cycle after the load, and every output sample equals the zero point. A later valid load clears the error.
- R8: The scale and zero-point inputs are sampled only in a cycle where the load strobe is high. Changes to them at other times have no effect on the outputs.
- R9: An accepted sample appears at the output after exactly two clock edges. With the output always ready, one sample is accepted every cycle.
- R10: While the output is valid and not ready, the output data and valid hold steady, the input is not ready, and no sample is lost or reordered.
- R11: After a synchronous active-low reset, the output is not valid, the configuration error is low and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Strobe that captures the scale pattern and zero point |
| cfg_scale_bits | input | 32 | Float bit pattern of the combined scale |
| cfg_zero_point | input | 8 | Signed output zero point |
| cfg_error | output | 1 | High when the loaded scale has its sign bit set |
| in_valid | input | 1 | Accumulator sample valid |
| in_ready | output | 1 | Unit can accept a sample |
| in_acc | input | 32 | Signed accumulator sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the output sample |
| out_data | output | 8 | Signed saturated output |

## Verification
Two things can happen in the same cycle:

- An output stall and a new input offer. A randomly dropped out_ready freezes the whole pipeline while the driver keeps offering input. The scoreboard then requires the frozen output to hold its value, and requires every result to leave in issue order.
- Rounding and saturation on one sample. A rounding carry can push a value past the 8-bit limit. Accumulators near the clamp boundaries are sent with a nonzero zero point, and each result is compared against a model built from the formulas in the requirements.

// File: rtl/requant_pkg.sv
// Shared constants and the decoded-configuration type for the requantization unit.
// Assumes a single-precision scale pattern and an 8-bit signed output.
package requant_pkg;
    localparam int SCALE_W      = 32;
    localparam int EXP_LSB      = 23;
    localparam int EXP_W        = 8;
    localparam int MULT_FRAC    = 15;
    localparam int MULT_LSB     = EXP_LSB - MULT_FRAC;
    localparam int MULT_W       = MULT_FRAC + 1;
    localparam int SHIFT_W      = 10;
    localparam int SHIFT_BIAS   = 127 + 31 - 32 + 16;
    localparam int ACC_W        = 32;
    localparam int PROD_W       = 48;
    localparam int WIDE_W       = 64;
    localparam int OUT_W        = 8;
    localparam int RSHIFT_LIMIT = 48;
    localparam int LSHIFT_CAP   = 16;

    typedef struct packed {
        logic [MULT_W-1:0]         mult;
        logic signed [SHIFT_W-1:0] shift;
        logic signed [OUT_W-1:0]   zp;
        logic                      err;
    } rq_cfg_t;
endpackage

// File: rtl/requant_scale_decode.sv
// Decodes a float scale pattern into a multiplier and a signed shift, captured on load.
// Assumes the load strobe is raised only while the data pipeline is empty.
module requant_scale_decode
    import requant_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [SCALE_W-1:0]       scale_bits,
    input  logic signed [OUT_W-1:0]  zero_point,
    output rq_cfg_t                  cfg
);
    logic [EXP_W-1:0]          exp_f;
    logic [MULT_FRAC-1:0]      man_f;
    logic signed [SHIFT_W-1:0] shift_next;
    logic [MULT_W-1:0]         mult_next;

    // Field extraction and bias arithmetic for the next configuration.
    always_comb begin
        exp_f      = scale_bits[EXP_LSB +: EXP_W];
        man_f      = scale_bits[MULT_LSB +: MULT_FRAC];
        shift_next = SHIFT_W'(SHIFT_BIAS) - SHIFT_W'(exp_f);
        mult_next  = MULT_W'(man_f) + MULT_W'(1);
    end

    // Configuration register, written only on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (load) begin
            cfg.mult  <= mult_next;
            cfg.shift <= shift_next;
            cfg.zp    <= zero_point;
            cfg.err   <= scale_bits[SCALE_W-1];
        end
    end

    // R2: a loaded multiplier is never zero.
    a_r2_mult_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cfg.mult != '0));

    // R8: without a load the decoded configuration holds.
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg));
endmodule

// File: rtl/requant_mul_stage.sv
// First pipeline stage: signed accumulator times unsigned multiplier into a 48-bit product.
// Assumes the product magnitude stays below 2^47, which holds for 32-bit by 16-bit operands.
module requant_mul_stage
    import requant_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     advance,
    input  logic                     in_valid,
    input  logic signed [ACC_W-1:0]  in_acc,
    input  logic [MULT_W-1:0]        mult,
    output logic                     s1_valid,
    output logic signed [PROD_W-1:0] s1_prod
);
    logic signed [PROD_W-1:0] acc_ext;
    logic signed [PROD_W-1:0] mult_ext;
    logic signed [PROD_W-1:0] prod_next;

    // Sign-extend both operands to the product width and multiply.
    always_comb begin
        acc_ext   = PROD_W'(in_acc);
        mult_ext  = PROD_W'($signed({1'b0, mult}));
        prod_next = acc_ext * mult_ext;
    end

    // Stage register; frozen whenever the pipeline stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_prod  <= '0;
        end else if (advance) begin
            s1_valid <= in_valid;
            s1_prod  <= prod_next;
        end
    end

    // R10: a stalled stage keeps its product.
    a_r10_s1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && s1_valid) |=> (s1_valid && $stable(s1_prod)));
endmodule

// File: rtl/requant_shift_sat.sv
// Second pipeline stage: rounding shift, zero-point add and 8-bit saturation.
// Assumes shift is in -113..142 and the product fits 48 signed bits.
module requant_shift_sat
    import requant_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     advance,
    input  logic                     s1_valid,
    input  logic signed [PROD_W-1:0] s1_prod,
    input  rq_cfg_t                  cfg,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);
    localparam logic signed [SHIFT_W-1:0] SH_FAR = SHIFT_W'(RSHIFT_LIMIT);
    localparam logic signed [SHIFT_W-1:0] SH_CAP = SHIFT_W'(LSHIFT_CAP);
    localparam logic signed [WIDE_W-1:0]  SAT_BIG = WIDE_W'(64'sd1048576);
    localparam logic signed [WIDE_W-1:0]  OUT_HI  = WIDE_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [WIDE_W-1:0]  OUT_LO  = -WIDE_W'(2 ** (OUT_W - 1));

    logic signed [WIDE_W-1:0]  wide;
    logic signed [WIDE_W-1:0]  rnd;
    logic signed [WIDE_W-1:0]  scaled;
    logic signed [WIDE_W-1:0]  sum;
    logic signed [SHIFT_W-1:0] lsh;
    logic [5:0]                rsh;
    logic signed [OUT_W-1:0]   res;

    // Select right, far or left shift, then add the zero point and clamp.
    always_comb begin
        wide   = WIDE_W'(s1_prod);
        rsh    = cfg.shift[5:0];
        lsh    = -cfg.shift;
        rnd    = '0;
        scaled = '0;
        if (cfg.shift >= SH_FAR) begin
            scaled = '0;
        end else if (cfg.shift > 0) begin
            rnd    = WIDE_W'(64'sd1) <<< (rsh - 6'd1);
            scaled = (wide + rnd) >>> rsh;
        end else if (s1_prod == '0) begin
            scaled = '0;
        end else if (lsh >= SH_CAP) begin
            scaled = s1_prod[PROD_W-1] ? -SAT_BIG : SAT_BIG;
        end else begin
            scaled = wide <<< lsh[3:0];
        end
        sum = scaled + WIDE_W'(cfg.zp);
        if (cfg.err)          res = cfg.zp;
        else if (sum > OUT_HI) res = OUT_HI[OUT_W-1:0];
        else if (sum < OUT_LO) res = OUT_LO[OUT_W-1:0];
        else                   res = sum[OUT_W-1:0];
    end

    // Output register; frozen whenever the consumer stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (advance) begin
            out_valid <= s1_valid;
            out_data  <= res;
        end
    end

    // R5: a product shifted by 48 or more leaves only the zero point.
    a_r5_far_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && s1_valid && (cfg.shift >= SH_FAR)) |=> (out_data == cfg.zp));
endmodule

// File: rtl/requant_unit.sv
// Requantization unit top: scale decode plus a two-stage, stall-together data pipeline.
// Assumes cfg_load is raised only when no sample is in flight or waiting at the output.
module requant_unit
    import requant_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic [SCALE_W-1:0]      cfg_scale_bits,
    input  logic signed [OUT_W-1:0] cfg_zero_point,
    output logic                    cfg_error,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [ACC_W-1:0] in_acc,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [OUT_W-1:0] out_data
);
    rq_cfg_t                  cfg;
    logic                     advance;
    logic                     s1_valid;
    logic signed [PROD_W-1:0] s1_prod;

    // Whole pipeline moves when the output slot is empty or being taken.
    always_comb begin
        advance   = !out_valid || out_ready;
        in_ready  = advance;
        cfg_error = cfg.err;
    end

    requant_scale_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .scale_bits (cfg_scale_bits),
        .zero_point (cfg_zero_point),
        .cfg        (cfg)
    );

    requant_mul_stage u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .in_valid (in_valid),
        .in_acc   (in_acc),
        .mult     (cfg.mult),
        .s1_valid (s1_valid),
        .s1_prod  (s1_prod)
    );

    requant_shift_sat u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .s1_valid  (s1_valid),
        .s1_prod   (s1_prod),
        .cfg       (cfg),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R10: a refused output keeps valid and data.
    a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9: an accepted sample occupies the first stage on the next cycle.
    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> s1_valid);

    // R7: with a negative scale every output is the zero point.
    a_r7_err_zp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_error) |-> (out_data == cfg.zp));
endmodule

// File: tb/requant_unit_bench.sv
// Scoreboard bench: the driver queues expected bytes, the monitor compares at the output.
module requant_unit_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [31:0]       cfg_scale_bits = '0;
    logic signed [7:0] cfg_zero_point = '0;
    logic              cfg_error;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic signed [31:0] in_acc = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic signed [7:0] out_data;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit rand_ready = 1'b0;
    logic [31:0] m_bits = '0;
    logic signed [7:0] m_zp = '0;
    logic signed [7:0] exp_q[$];
    string tag_q[$];
    bit stalled = 1'b0;
    logic signed [7:0] held;

    always #10 clk = ~clk;

    requant_unit u_requant_unit (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_scale_bits(cfg_scale_bits),
        .cfg_zero_point(cfg_zero_point), .cfg_error(cfg_error), .in_valid(in_valid),
        .in_ready(in_ready), .in_acc(in_acc), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] mk_scale(bit s, int e, int m15);
        return {s, 8'(e), 15'(m15), 8'h00};
    endfunction

    // Model from R1..R7.
    function automatic logic signed [7:0] model(int acc, logic [31:0] sb, logic signed [7:0] zp);
        int sh;
        longint p, r, m;
        if (sb[31]) return zp;
        sh = 142 - int'(sb[30:23]);
        m  = longint'(sb[22:8]) + 1;
        p  = longint'(acc) * m;
        if (sh >= 48)       r = 0;
        else if (sh >= 1)   r = (p + (longint'(1) <<< (sh - 1))) >>> sh;
        else if (p == 0)    r = 0;
        else if (-sh >= 16) r = (p > 0) ? 64'sd1048576 : -64'sd1048576;
        else                r = p <<< (-sh);
        r = r + longint'(zp);
        if (r > 127)  r = 127;
        if (r < -128) r = -128;
        return 8'(r);
    endfunction

    task automatic check(bit ok, string tag, longint act, longint expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Output ready pattern, changed just after each edge.
    initial forever begin
        @(posedge clk); #1;
        out_ready = rand_ready ? ($urandom % 4 != 0) : 1'b1;
    end

    // Monitor: compare consumed outputs and check stall holding (R10).
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (stalled) check(out_valid && out_data == held, "R10 hold", out_data, held);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) check(1'b0, "R9 unexpected output", out_data, 0);
                else begin
                    logic signed [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data == e, t, out_data, e);
                end
            end
            stalled = out_valid && !out_ready;
            held = out_data;
        end
    end

    // Driver: offer one sample and push its expected value at handshake.
    task automatic send(int a, string tag);
        in_valid = 1'b1;
        in_acc = a;
        forever begin
            @(negedge clk);
            if (in_ready) begin
                exp_q.push_back(model(a, m_bits, m_zp));
                tag_q.push_back(tag);
                @(posedge clk); #1;
                break;
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || out_valid) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic load(logic [31:0] sb, logic signed [7:0] zp);
        drain();
        cfg_scale_bits = sb;
        cfg_zero_point = zp;
        cfg_load = 1'b1;
        m_bits = sb;
        m_zp = zp;
        @(posedge clk); #1;
        cfg_load = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R9 watchdog", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        check(!out_valid, "R11 out_valid", out_valid, 0);
        check(!cfg_error, "R11 cfg_error", cfg_error, 0);
        check(in_ready, "R11 in_ready", in_ready, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R3: shift 8, multiplier 128 gives acc/2 rounded half up.
        load(mk_scale(0, 134, 127), 8'sd0);
        send(3, "R3 +1.5");
        send(-3, "R3 -1.5");
        send(5, "R3 +2.5");
        send(-5, "R3 -2.5");
        // R1/R2: general scaling with zero point.
        load(mk_scale(0, 130, 16'h4A3C), -8'sd7);
        for (int i = -40; i < 40; i += 7) send(i * 1013, "R1 scale");
        // R4: saturation both sides with a zero point.
        load(mk_scale(0, 134, 255), 8'sd20);
        send(107, "R4 edge hi");
        send(108, "R4 sat hi");
        send(-148, "R4 edge lo");
        send(-149, "R4 sat lo");
        send(32'sh7FFFFFFF, "R4 max acc");
        send(32'sh80000000, "R4 min acc");
        // R5: shift 48 and 47.
        load(mk_scale(0, 94, 32767), 8'sd5);
        send(32'sh7FFFFFFF, "R5 shift48");
        send(32'sh80000000, "R5 shift48 neg");
        load(mk_scale(0, 95, 32767), 8'sd0);
        send(32'sh7FFFFFFF, "R5 shift47");
        // R6: shift 0, -3 and -18.
        load(mk_scale(0, 142, 0), 8'sd0);
        send(5, "R6 shift0");
        load(mk_scale(0, 145, 0), 8'sd0);
        send(3, "R6 left3");
        send(20, "R6 left3 sat");
        send(-1, "R6 left3 neg");
        load(mk_scale(0, 160, 0), 8'sd9);
        send(1, "R6 cap pos");
        send(-1, "R6 cap neg");
        send(0, "R6 zero");
        // R7: negative scale.
        load(mk_scale(1, 130, 500), -8'sd3);
        @(negedge clk);
        check(cfg_error, "R7 error flag", cfg_error, 1);
        @(posedge clk); #1;
        send(1000, "R7 forced zp");
        send(-99999, "R7 forced zp");
        load(mk_scale(0, 130, 500), -8'sd3);
        @(negedge clk);
        check(!cfg_error, "R7 error cleared", cfg_error, 0);
        @(posedge clk); #1;
        // R8: inputs move without a load.
        cfg_scale_bits = mk_scale(1, 10, 3);
        cfg_zero_point = 8'sd100;
        send(777, "R8 no load");
        send(-777, "R8 no load");
        // R9: latency and throughput.
        drain();
        send(50, "R9 value");
        @(negedge clk);
        check(!out_valid, "R9 latency edge1", out_valid, 0);
        @(negedge clk);
        check(out_valid, "R9 latency edge2", out_valid, 1);
        drain();
        begin
            int c0;
            c0 = cyc;
            for (int i = 0; i < 8; i++) send(i * 300, "R9 burst");
            check(cyc - c0 == 8, "R9 throughput", cyc - c0, 8);
        end
        // R10 and mixed: random stream under backpressure.
        rand_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            load(mk_scale(($urandom % 7) == 0, 80 + ($urandom % 81), $urandom % 32768),
                 8'($urandom));
            for (int j = 0; j < 200; j++) begin
                int a;
                a = ($urandom % 2) ? int'($urandom) : (int'($urandom % 4001) - 2000);
                send(a, "R10 stream");
            end
        end
        rand_ready = 1'b0;
        drain();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule